// File: doc/BRIEF.md
# Synchronous Burst Static RAM

This block is a synthesizable behavioural model of a clocked static RAM with a built-in four-beat burst sequencer. It presents a 16-bit word address and a 32-bit data word. Every control input, the address and the write data are sampled on the rising clock edge. A burst begins on a cycle where either of two address strobes is low. One strobe comes from the host processor and the other from a memory controller. Later cycles step through the remaining three words of the aligned group of four, either in linear (wrap-around add) order or in interleaved (XOR) order. The order depends on a static select input.

Read data is presented either in flow-through form or in pipelined form. Flow-through data appears in the cycle that follows the sampling edge. Pipelined data appears one edge later. The output enable gates the data drive with no clock involved. A strap sampled during reset decides what a deselect does to a running read burst. With the strap low, no data follows the deselect. With the strap high, the last word is repeated for one more cycle, so that two banks can hand over with no gap. A sleep input makes the block ignore a cycle completely. Each byte lane can be written on its own, and a global write writes all four lanes.

The storage depth is the parameter `MEM_AW`, which defaults to 256 words for simulation. Address bits above it are carried through the burst logic but do not select storage.

Top module: `burst_sram`

## Requirements
- R1: While reset is held and in the cycles after it with no access, `rdata_drive_o` is 0 and `rdata_o` is all zeros.
- R2: When either strobe is low and all three selects are active (`sel_a_n_i`=0, `sel_b_i`=1, `sel_c_n_i`=0), the cycle starts a burst at `addr_i` with the beat count at zero. A cycle with `host_strobe_n_i` low is always a read, whatever the write inputs say. A cycle started only by `ctrl_strobe_n_i` writes if any lane is enabled, and reads otherwise.
- R3: In a running burst, a cycle with both strobes high and `step_n_i`=0 accesses the next beat. A cycle with `step_n_i`=1 accesses the same word again. After four beats the count wraps back to the start word.
- R4: The two low address bits of beat k are (start+k) mod 4 when `seq_linear_i`=1, and start XOR k when `seq_linear_i`=0. The upper address bits keep their start value for the whole burst.
- R5: `wr_all_n_i`=0 writes all four lanes. Otherwise, when `lane_wr_en_n_i`=0, each lane i with `lane_wr_n_i[i]`=0 writes bits 8i+7..8i. Lane strobes with `lane_wr_en_n_i`=1 write nothing.
- R6: A read sampled at edge n drives its word after edge n when `pass_through_i`=1, and after edge n+1 when `pass_through_i`=0.
- R7: `rdata_drive_o` is 1 only while `out_en_n_i`=0 and a read word is due, and it follows `out_en_n_i` without waiting for a clock. `rdata_o` is zero whenever it is not driven.
- R8: A cycle with a strobe low while any select is inactive ends the burst. Later cycles with both strobes high make no access until a new burst starts.
- R9: With the reset-time strap low, the slot of a deselect cycle carries no data.
- R10: With the reset-time strap high, a deselect that directly follows a read repeats that read's word in its own slot. This happens only once, even if a second deselect follows.
- R11: `keep_strap_i` is sampled only while reset is held, and changing it afterwards has no effect.
- R12: A cycle with `sleep_i`=1 writes nothing, leaves the beat count and burst state unchanged, and produces no read word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | 16 | Word address, taken on a burst start |
| wdata_i | input | 32 | Write data |
| sel_a_n_i | input | 1 | Primary chip select, active low |
| sel_b_i | input | 1 | Secondary chip select, active high |
| sel_c_n_i | input | 1 | Secondary chip select, active low |
| host_strobe_n_i | input | 1 | Processor address strobe, active low, always read |
| ctrl_strobe_n_i | input | 1 | Controller address strobe, active low |
| step_n_i | input | 1 | Burst advance, active low |
| wr_all_n_i | input | 1 | Global write of all lanes, active low |
| lane_wr_en_n_i | input | 1 | Enable for the per-lane write strobes, active low |
| lane_wr_n_i | input | 4 | Per-lane write strobes, active low, bit i = bits 8i+7..8i |
| out_en_n_i | input | 1 | Output enable, active low, not clocked |
| seq_linear_i | input | 1 | Burst order: 1 linear, 0 interleaved |
| pass_through_i | input | 1 | 1 flow-through read output, 0 pipelined |
| sleep_i | input | 1 | Low-power request; cycle ignored |
| keep_strap_i | input | 1 | Deselect behaviour strap, sampled during reset |
| rdata_o | output | 32 | Read data, zero when not driven |
| rdata_drive_o | output | 1 | High when the data bus is driven (pad enable) |

## Verification
A flow-through word is due in the half cycle after the edge that sampled its access. A pipelined word is due one edge later. A repeated word after a deselect follows the same rule, counted from the deselect edge. The drive enable answers the output enable with no edge at all. The bench numbers every rising edge. Its behavioural model files each expected word under the edge index at which it is due. At the falling edge after every rising edge, the bench compares both outputs against that entry. It also compares a few nanoseconds after it toggles the output enable between edges.

// File: rtl/burst_sram_pkg.sv
// Shared types and helpers for the burst static RAM.
// Assumes a four-beat burst, so the beat count is always two bits wide.
package burst_sram_pkg;

    // What a sampled clock edge does to the burst sequencer.
    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,   // no access, no state change
        CYC_DESEL = 2'd1,   // strobe while unselected: burst ends
        CYC_START = 2'd2,   // strobe while selected: new burst
        CYC_CONT  = 2'd3    // no strobe, burst running: next or same beat
    } cyc_kind_e;

    // Low two address bits of a beat, from start bits and beat count.
    function automatic logic [1:0] beat_low(
        input logic [1:0] origin,
        input logic [1:0] beat,
        input logic       linear
    );
        logic [1:0] sum;
        sum = origin + beat;
        return linear ? sum : (origin ^ beat);
    endfunction

endpackage

// File: rtl/bsr_ctrl.sv
// Burst sequencer: decodes the sampled controls into one cycle kind and
// keeps the start address, beat count and running flag. It produces the
// storage index and the read/write decision for the access this edge makes.
// Assumes MEM_AW >= 3 and MEM_AW <= ADDR_W; address bits above MEM_AW are
// held but select no storage.
module bsr_ctrl
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int MEM_AW = 8,
    parameter int NB     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              sel_a_n_i,
    input  logic              sel_b_i,
    input  logic              sel_c_n_i,
    input  logic              host_strobe_n_i,
    input  logic              ctrl_strobe_n_i,
    input  logic              step_n_i,
    input  logic              wr_all_n_i,
    input  logic              lane_wr_en_n_i,
    input  logic [NB-1:0]     lane_wr_n_i,
    input  logic              seq_linear_i,
    input  logic              sleep_i,
    output logic              acc_read_o,
    output logic              acc_write_o,
    output logic              desel_o,
    output logic [MEM_AW-1:0] acc_idx_o,
    output logic [NB-1:0]     lane_mask_o
);

    localparam int CNT_W = 2;

    cyc_kind_e          kind;
    logic               chosen;
    logic               any_strobe;
    logic               acc_valid;
    logic               host_read;
    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   cnt_next;
    logic               active_q;
    logic [ADDR_W-1:0]  base_q;
    logic [ADDR_W-1:0]  eff_base;

    assign chosen     = !sel_a_n_i && sel_b_i && !sel_c_n_i;
    assign any_strobe = !host_strobe_n_i || !ctrl_strobe_n_i;

    // Classify the cycle; sleep overrides everything else.
    always_comb begin
        if (sleep_i)                 kind = CYC_IDLE;
        else if (any_strobe && chosen) kind = CYC_START;
        else if (any_strobe)         kind = CYC_DESEL;
        else if (active_q)           kind = CYC_CONT;
        else                         kind = CYC_IDLE;
    end

    // Beat count used by this edge's access.
    always_comb begin
        unique case (kind)
            CYC_START: cnt_next = '0;
            CYC_CONT:  cnt_next = step_n_i ? cnt_q : cnt_q + 1'b1;
            default:   cnt_next = cnt_q;
        endcase
    end

    // Lane write mask from global and per-lane write inputs.
    always_comb begin
        if (!wr_all_n_i)          lane_mask_o = '1;
        else if (!lane_wr_en_n_i) lane_mask_o = ~lane_wr_n_i;
        else                      lane_mask_o = '0;
    end

    assign eff_base    = (kind == CYC_START) ? addr_i : base_q;
    assign acc_valid   = (kind == CYC_START) || (kind == CYC_CONT);
    assign host_read   = (kind == CYC_START) && !host_strobe_n_i;
    assign acc_write_o = acc_valid && !host_read && (lane_mask_o != '0);
    assign acc_read_o  = acc_valid && !acc_write_o;
    assign desel_o     = (kind == CYC_DESEL);
    assign acc_idx_o   = {eff_base[MEM_AW-1:2],
                          beat_low(eff_base[1:0], cnt_next, seq_linear_i)};

    // Burst state: start address, beat count, running flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q   <= '0;
            cnt_q    <= '0;
            active_q <= 1'b0;
        end else begin
            unique case (kind)
                CYC_START: begin
                    base_q   <= addr_i;
                    cnt_q    <= '0;
                    active_q <= 1'b1;
                end
                CYC_DESEL: active_q <= 1'b0;
                CYC_CONT:  cnt_q    <= cnt_next;
                default: ;
            endcase
        end
    end

    // R4: the start address does not move while the burst continues.
    p_base_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == CYC_CONT) |=> $stable(base_q));

    // R3: the fourth advance returns to the start beat.
    p_cnt_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == CYC_CONT && !step_n_i && cnt_q == 2'd3) |=> (cnt_q == 2'd0));

    // R12: a sleep cycle freezes the burst state.
    p_sleep_freeze_r12: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |=> ($stable(cnt_q) && $stable(active_q) && $stable(base_q)));

    // R8: a deselect leaves no burst running.
    p_desel_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == CYC_DESEL) |=> !active_q);

endmodule

// File: rtl/bsr_array.sv
// Storage array, split into one independent memory per byte lane so that
// each lane has a single writer. One write port (clocked) and one read port
// (combinational, indexed by the output path). Contents are not reset.
module bsr_array #(
    parameter int MEM_AW = 8,
    parameter int DATA_W = 32,
    parameter int NB     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [MEM_AW-1:0] wr_idx_i,
    input  logic [NB-1:0]     wr_mask_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [MEM_AW-1:0] rd_idx_i,
    output logic [DATA_W-1:0] rd_data_o
);

    localparam int DEPTH  = 1 << MEM_AW;
    localparam int LANE_W = DATA_W / NB;

    for (genvar g = 0; g < NB; g++) begin : g_lane
        logic [LANE_W-1:0] lane_q [DEPTH];

        // Write this lane when the access writes and its mask bit is set.
        always_ff @(posedge clk) begin
            if (wr_en_i && wr_mask_i[g])
                lane_q[wr_idx_i] <= wr_data_i[g*LANE_W +: LANE_W];
        end

        assign rd_data_o[g*LANE_W +: LANE_W] = lane_q[rd_idx_i];
    end

    // R5: no write is issued with an empty lane mask.
    p_lane_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |-> (wr_mask_i != '0));

endmodule

// File: rtl/bsr_outpath.sv
// Read output path: a stage holding the index of the word being read, an
// optional output register for pipelined mode, the deselect extension
// selected by the reset-time strap, and the unclocked output-enable gate.
// Assumes the pass-through select changes only while no read is in flight.
module bsr_outpath #(
    parameter int MEM_AW = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              keep_strap_i,
    input  logic              pass_through_i,
    input  logic              out_en_n_i,
    input  logic              acc_read_i,
    input  logic [MEM_AW-1:0] acc_idx_i,
    input  logic              desel_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic [MEM_AW-1:0] rd_idx_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rdata_drive_o
);

    logic              strap_q;
    logic              s1_valid_q;
    logic              s1_held_q;
    logic [MEM_AW-1:0] s1_idx_q;
    logic              s2_valid_q;
    logic [DATA_W-1:0] s2_data_q;
    logic              hold_now;
    logic              beat_valid;
    logic [DATA_W-1:0] beat_data;

    assign hold_now = strap_q && desel_i && s1_valid_q && !s1_held_q;

    // Capture the deselect strap only while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) strap_q <= keep_strap_i;
    end

    // First stage: which word is being read, and whether it is a repeat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid_q <= 1'b0;
            s1_held_q  <= 1'b0;
            s1_idx_q   <= '0;
        end else if (hold_now) begin
            s1_held_q  <= 1'b1;
        end else begin
            s1_valid_q <= acc_read_i;
            s1_held_q  <= 1'b0;
            if (acc_read_i) s1_idx_q <= acc_idx_i;
        end
    end

    // Second stage: registered copy of the word for pipelined mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_valid_q <= 1'b0;
            s2_data_q  <= '0;
        end else begin
            s2_valid_q <= s1_valid_q;
            s2_data_q  <= rd_data_i;
        end
    end

    assign rd_idx_o   = s1_idx_q;
    assign beat_valid = pass_through_i ? s1_valid_q : s2_valid_q;
    assign beat_data  = pass_through_i ? rd_data_i : s2_data_q;

    // Output enable gates the drive with no register in the way.
    assign rdata_drive_o = beat_valid && !out_en_n_i;
    assign rdata_o       = rdata_drive_o ? beat_data : '0;

    // R10: a repeated word comes only from a high strap.
    p_hold_needs_strap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        s1_held_q |-> strap_q);

    // R10: never two repeats in a row.
    p_hold_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        s1_held_q |=> !s1_held_q);

    // R9: with a low strap a deselect slot is empty.
    p_no_hold_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!strap_q && desel_i) |=> !s1_valid_q);

    // R7: the bus is never driven while output enable is high.
    p_drive_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_drive_o |-> !out_en_n_i);

endmodule

// File: rtl/burst_sram.sv
// Top level of the burst static RAM: sequencer, lane-split storage and read
// output path. All sampling is on the rising edge of clk; reset is
// synchronous and active low; the data drive enable is meant for a pad.
module burst_sram #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int MEM_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              sel_a_n_i,
    input  logic              sel_b_i,
    input  logic              sel_c_n_i,
    input  logic              host_strobe_n_i,
    input  logic              ctrl_strobe_n_i,
    input  logic              step_n_i,
    input  logic              wr_all_n_i,
    input  logic              lane_wr_en_n_i,
    input  logic [DATA_W/8-1:0] lane_wr_n_i,
    input  logic              out_en_n_i,
    input  logic              seq_linear_i,
    input  logic              pass_through_i,
    input  logic              sleep_i,
    input  logic              keep_strap_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rdata_drive_o
);

    localparam int NB = DATA_W / 8;

    logic              acc_read;
    logic              acc_write;
    logic              desel;
    logic [MEM_AW-1:0] acc_idx;
    logic [NB-1:0]     lane_mask;
    logic [MEM_AW-1:0] rd_idx;
    logic [DATA_W-1:0] rd_data;

    bsr_ctrl #(
        .ADDR_W (ADDR_W),
        .MEM_AW (MEM_AW),
        .NB     (NB)
    ) u_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .addr_i          (addr_i),
        .sel_a_n_i       (sel_a_n_i),
        .sel_b_i         (sel_b_i),
        .sel_c_n_i       (sel_c_n_i),
        .host_strobe_n_i (host_strobe_n_i),
        .ctrl_strobe_n_i (ctrl_strobe_n_i),
        .step_n_i        (step_n_i),
        .wr_all_n_i      (wr_all_n_i),
        .lane_wr_en_n_i  (lane_wr_en_n_i),
        .lane_wr_n_i     (lane_wr_n_i),
        .seq_linear_i    (seq_linear_i),
        .sleep_i         (sleep_i),
        .acc_read_o      (acc_read),
        .acc_write_o     (acc_write),
        .desel_o         (desel),
        .acc_idx_o       (acc_idx),
        .lane_mask_o     (lane_mask)
    );

    bsr_array #(
        .MEM_AW (MEM_AW),
        .DATA_W (DATA_W),
        .NB     (NB)
    ) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (acc_write),
        .wr_idx_i  (acc_idx),
        .wr_mask_i (lane_mask),
        .wr_data_i (wdata_i),
        .rd_idx_i  (rd_idx),
        .rd_data_o (rd_data)
    );

    bsr_outpath #(
        .MEM_AW (MEM_AW),
        .DATA_W (DATA_W)
    ) u_out (
        .clk            (clk),
        .rst_n          (rst_n),
        .keep_strap_i   (keep_strap_i),
        .pass_through_i (pass_through_i),
        .out_en_n_i     (out_en_n_i),
        .acc_read_i     (acc_read),
        .acc_idx_i      (acc_idx),
        .desel_i        (desel),
        .rd_data_i      (rd_data),
        .rd_idx_o       (rd_idx),
        .rdata_o        (rdata_o),
        .rdata_drive_o  (rdata_drive_o)
    );

endmodule

// File: tb/burst_sram_test.sv
// Bench: a behavioural model numbers every rising edge, schedules each
// expected read word under the edge at which it is due, and is compared
// against the outputs half a period after every edge.
module burst_sram_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] t_addr = '0;
    logic [31:0] t_wd = '0;
    logic        t_sela = 1'b1, t_selb = 1'b0, t_selc = 1'b1;
    logic        t_host = 1'b1, t_ctrl = 1'b1, t_step = 1'b1;
    logic        t_gw = 1'b1, t_bwe = 1'b1;
    logic [3:0]  t_bw = 4'hF;
    logic        t_oe_n = 1'b0, t_lin = 1'b1, t_pass = 1'b0;
    logic        t_sleep = 1'b0, t_strap = 1'b0;
    logic [31:0] rdata_o;
    logic        rdata_drive_o;

    int    vectors = 0;
    int    fails = 0;
    int    n = 0;
    bit    done = 0;
    string cur_req = "R1";

    // model state
    logic [31:0] mmem [256];
    bit          exp_v [int];
    logic [31:0] exp_d [int];
    bit          m_active = 0;
    logic [15:0] m_base = '0;
    int          m_cnt = 0;
    bit          m_strap = 0;
    bit          last_real = 0;
    logic [31:0] last_data = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_sram uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .addr_i          (t_addr),
        .wdata_i         (t_wd),
        .sel_a_n_i       (t_sela),
        .sel_b_i         (t_selb),
        .sel_c_n_i       (t_selc),
        .host_strobe_n_i (t_host),
        .ctrl_strobe_n_i (t_ctrl),
        .step_n_i        (t_step),
        .wr_all_n_i      (t_gw),
        .lane_wr_en_n_i  (t_bwe),
        .lane_wr_n_i     (t_bw),
        .out_en_n_i      (t_oe_n),
        .seq_linear_i    (t_lin),
        .pass_through_i  (t_pass),
        .sleep_i         (t_sleep),
        .keep_strap_i    (t_strap),
        .rdata_o         (rdata_o),
        .rdata_drive_o   (rdata_drive_o)
    );

    task automatic emit(input logic [31:0] d);
        int due;
        due = t_pass ? n : n + 1;
        exp_v[due] = 1'b1;
        exp_d[due] = d;
    endtask

    task automatic access(input bit host_start);
        logic [1:0]  low;
        logic [7:0]  idx;
        logic [3:0]  mask;
        logic [31:0] d;
        low = t_lin ? 2'(m_base[1:0] + 2'(m_cnt)) : (m_base[1:0] ^ 2'(m_cnt));
        idx = {m_base[7:2], low};
        if (!t_gw) mask = 4'hF;
        else if (!t_bwe) mask = ~t_bw;
        else mask = 4'h0;
        if (!host_start && mask != 4'h0) begin
            d = mmem[idx];
            for (int b = 0; b < 4; b++)
                if (mask[b]) d[b*8 +: 8] = t_wd[b*8 +: 8];
            mmem[idx] = d;
            last_real = 0;
        end else begin
            d = mmem[idx];
            emit(d);
            last_real = 1;
            last_data = d;
        end
    endtask

    // Model of one rising edge with the inputs currently driven.
    task automatic model_edge();
        bit sel, stb;
        n++;
        if (!rst_n) begin
            m_strap = t_strap; m_active = 0; m_cnt = 0; last_real = 0;
            return;
        end
        if (t_sleep) begin last_real = 0; return; end
        sel = !t_sela && t_selb && !t_selc;
        stb = !t_host || !t_ctrl;
        if (stb && sel) begin
            m_base = t_addr; m_cnt = 0; m_active = 1;
            access(!t_host);
        end else if (stb) begin
            m_active = 0;
            if (m_strap && last_real) emit(last_data);
            last_real = 0;
        end else if (m_active) begin
            if (!t_step) m_cnt = (m_cnt + 1) % 4;
            access(0);
        end else begin
            last_real = 0;
        end
    endtask

    task automatic compare();
        bit          ev, eoe;
        logic [31:0] ed, edq;
        ev  = exp_v.exists(n) ? exp_v[n] : 1'b0;
        ed  = ev ? exp_d[n] : '0;
        eoe = ev && !t_oe_n;
        edq = eoe ? ed : '0;
        vectors++;
        if (rdata_drive_o !== eoe || rdata_o !== edq) begin
            fails++;
            $display("FAIL %s edge %0d: drive=%0b data=%h, expected drive=%0b data=%h",
                     cur_req, n, rdata_drive_o, rdata_o, eoe, edq);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic rest();
        t_host = 1; t_ctrl = 1; t_step = 1; t_gw = 1; t_bwe = 1; t_bw = 4'hF;
        t_sela = 0; t_selb = 1; t_selc = 0; t_sleep = 0;
    endtask

    task automatic read_start(input logic [15:0] a);
        rest(); t_host = 0; t_addr = a; tick();
    endtask

    task automatic write_start(input logic [15:0] a, input logic [31:0] d);
        rest(); t_ctrl = 0; t_gw = 0; t_addr = a; t_wd = d; tick();
    endtask

    task automatic step_read();
        rest(); t_step = 0; tick();
    endtask

    task automatic step_write(input logic [31:0] d);
        rest(); t_step = 0; t_gw = 0; t_wd = d; tick();
    endtask

    task automatic deselect();
        rest(); t_host = 0; t_sela = 1; tick();
    endtask

    task automatic idle(input int k);
        deselect();
        for (int i = 0; i < k; i++) begin rest(); tick(); end
    endtask

    initial begin
        // R1: reset state, strap low
        cur_req = "R1";
        rest(); t_strap = 0; rst_n = 0;
        repeat (3) tick();
        rst_n = 1;
        rest(); tick(); tick();

        // R2, R5: burst writes through the controller strobe
        cur_req = "R2";
        write_start(16'h0010, 32'hA0A0_0001);
        step_write(32'hA0A0_0002);
        step_write(32'hA0A0_0003);
        step_write(32'hA0A0_0004);
        idle(2);
        write_start(16'h0020, 32'hB0B0_0001);
        step_write(32'hB0B0_0002);
        step_write(32'hB0B0_0003);
        step_write(32'hB0B0_0004);
        idle(2);

        // R3, R4: linear order from beat 1, wrap and repeat (pipelined)
        cur_req = "R3";
        t_lin = 1;
        read_start(16'h0011);
        for (int i = 0; i < 4; i++) step_read();
        rest(); tick();
        idle(2);

        // R4: interleaved order from beat 3 and from beat 1
        cur_req = "R4";
        t_lin = 0;
        read_start(16'h0013);
        for (int i = 0; i < 3; i++) step_read();
        idle(1);
        read_start(16'h0021);
        for (int i = 0; i < 3; i++) step_read();
        idle(2);
        t_lin = 1;

        // R5: lane writes, enable qualifier, global write
        cur_req = "R5";
        write_start(16'h0030, 32'hFFFF_FFFF);
        idle(1);
        rest(); t_ctrl = 0; t_addr = 16'h0030; t_bwe = 0; t_bw = 4'b1010;
        t_wd = 32'h1234_5678; tick();
        idle(1);
        rest(); t_ctrl = 0; t_addr = 16'h0030; t_bwe = 1; t_bw = 4'b0000;
        t_wd = 32'h0000_0000; tick();
        idle(2);

        // R2: host strobe reads even with write inputs active
        cur_req = "R2";
        rest(); t_host = 0; t_addr = 16'h0030; t_gw = 0; t_wd = 32'hDEAD_BEEF; tick();
        idle(1);
        read_start(16'h0030);
        idle(2);

        // R6: flow-through latency
        cur_req = "R6";
        t_pass = 1;
        read_start(16'h0010);
        for (int i = 0; i < 3; i++) step_read();
        idle(2);

        // R7: output enable acts between edges
        cur_req = "R7";
        read_start(16'h0012);
        t_oe_n = 1; #1; compare();
        t_oe_n = 0; #1; compare();
        t_oe_n = 1; step_read();
        t_oe_n = 0; step_read();
        idle(2);

        // R8, R9: deselect ends burst, strap low gives empty slot
        cur_req = "R9";
        t_pass = 0;
        read_start(16'h0020);
        step_read();
        deselect();
        cur_req = "R8";
        step_read(); step_read();
        rest(); tick();
        t_pass = 1;
        cur_req = "R9";
        read_start(16'h0022);
        deselect();
        cur_req = "R8";
        step_read();
        idle(2);

        // R12: sleep cycle inside a burst
        cur_req = "R12";
        t_pass = 0;
        read_start(16'h0010);
        rest(); t_sleep = 1; t_step = 0; t_gw = 0; t_wd = 32'h5555_5555; tick();
        rest(); t_sleep = 1; t_host = 0; t_addr = 16'h0020; tick();
        step_read(); step_read();
        idle(2);
        read_start(16'h0010);
        for (int i = 0; i < 4; i++) step_read();
        idle(2);

        // R10, R11: strap high at reset, low afterwards
        cur_req = "R11";
        rst_n = 0; t_strap = 1;
        rest(); tick(); tick();
        rst_n = 1; t_strap = 0;
        rest(); tick();
        cur_req = "R10";
        read_start(16'h0010);
        step_read();
        deselect();
        deselect();
        rest(); tick(); tick();
        t_pass = 1;
        read_start(16'h0020);
        step_read();
        deselect();
        deselect();
        rest(); tick();
        write_start(16'h0033, 32'h0BAD_F00D);
        deselect();
        rest(); tick(); tick();

        cur_req = "R1";
        rest(); tick();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog (%s): run still active, expected completion", cur_req);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule